// File: doc/BRIEF.md
# External Interrupt Detect and Priority Unit

This block watches a small group of external interrupt pins on behalf of an 8-bit processor core. Each pin can be set to one of four trigger modes: low level, high level, falling edge or rising edge. Two configuration bits per pin choose the mode. In edge mode, a detected edge latches a pending flag. That flag stays set until the core acknowledges the interrupt or clears it through a register write. In level mode, the pending indication follows the synchronized pin directly.

Every source has an enable bit and a priority level from 0 to 3. The level is built from one bit in a high-priority register and one bit in a low-priority register. An external mask input can force any source off. Among the sources that are pending, enabled and not masked, the block presents one winner to the core as a valid bit, a source index and a level. The core reaches all configuration through a simple register port: a write strobe, an address, write data and combinational read data. When the core begins servicing an interrupt, it pulses an acknowledge carrying the source index.

Top module: `extint_unit`

## Requirements
- R1: With its type bit at 0, a source is level-triggered. It is pending while its synchronized pin is low, or while the pin is high when its polarity bit is 1. In this mode the flag register bit reads back that pending state.
- R2: With its type bit at 1, a source is edge-triggered. Its flag is latched by a falling edge on the pin, or by a rising edge when its polarity bit is 1. An edge in the other direction leaves the flag unchanged, and the flag holds after the pin returns.
- R3: An acknowledge pulse for an edge-triggered source clears that source's flag. For a level-triggered source the acknowledge has no effect.
- R4: A write to the flag register sets or clears the flags of edge-triggered sources to the written bits. For level-triggered sources the written bits are ignored.
- R5: When a hardware edge and a register write that clears the same flag arrive in the same cycle, the flag ends up set.
- R6: A source whose enable bit is 0, or whose mask input is 1, never causes irq_valid, even while it is pending.
- R7: A source's level is {high bit, low bit}. The highest level among eligible sources wins, and ties go to the lowest index. irq_idx and irq_level report the winner, and irq_valid is 1 exactly when at least one source is eligible.
- R8: After reset, all type, polarity, enable and priority bits are 0, and irq_valid is 0.
- R9: Register map. Each register holds bit i for source i. Address 0 holds type, 1 holds polarity, 2 holds enable, 3 holds the flags, 4 holds the low priority bits and 5 holds the high priority bits. Addresses 6 and 7, and all bits above the source count, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | NSRC | Asynchronous external interrupt pins |
| src_mask | input | NSRC | Forces the matching source off while 1 |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW | Register write data |
| bus_rdata | output | DW | Register read data (combinational) |
| ack_valid | input | 1 | Service-begin acknowledge pulse |
| ack_idx | input | IDXW | Source being acknowledged |
| irq_valid | output | 1 | A request is presented |
| irq_idx | output | IDXW | Index of the winning source |
| irq_level | output | 2 | Priority level of the winner |

## Verification
The bound checker checks the following on every cycle:
- the presented winner is pending, enabled and unmasked;
- its reported level matches its priority bits;
- no eligible source outranks it;
- irq_valid is raised whenever any source is eligible;
- a selected edge always leaves the flag set on the next cycle, even when a clearing write arrives in that cycle;
- an acknowledge with no competing edge or write clears the flag.

Only the bench scenarios can show the following:
- edge direction selection and insensitivity to the opposite edge;
- level-mode readback, and that acknowledges and writes are ignored in level mode;
- reserved-bit readback and reset values;
- the tie order across many random configurations.

// File: rtl/extint_pkg.sv
// Package: shared types and register selectors for the external interrupt unit.
// Assumes register addresses fit in three bits; wider address buses zero-extend them.
package extint_pkg;

    localparam int LVL_W = 2;

    typedef logic [LVL_W-1:0] prio_t;

    typedef enum logic [2:0] {
        RS_TYPE = 3'd0,
        RS_POL  = 3'd1,
        RS_EN   = 3'd2,
        RS_FLAG = 3'd3,
        RS_PLO  = 3'd4,
        RS_PHI  = 3'd5
    } reg_sel_e;

endpackage

// File: rtl/extint_sync.sv
// Module: two-flop synchronizer plus one history stage for each pin.
// Provides the settled level and single-cycle rise/fall strobes.
// Assumes pins are asynchronous and that the history stage resets to 0.
module extint_sync #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_async,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;
    logic [N-1:0] hist_q;

    // Resample the pins through two flops, then keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= pin_async;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    // Derive the level and transition strobes from the synchronized samples.
    always_comb begin
        lvl  = sync_q;
        rise = sync_q & ~hist_q;
        fall = ~sync_q & hist_q;
    end
endmodule

// File: rtl/extint_src.sv
// Module: pending logic for one interrupt source.
// Level mode: pending tracks the selected pin level and is never stored.
// Edge mode: a selected edge sets the flag, and that set beats a register write,
// which in turn beats an acknowledge.
// Assumes the write and acknowledge strobes last one cycle each.
module extint_src (
    input  logic clk,
    input  logic rst_n,
    input  logic is_edge,
    input  logic pol,
    input  logic lvl,
    input  logic rise,
    input  logic fall,
    input  logic wr_en,
    input  logic wr_val,
    input  logic ack_hit,
    output logic edge_hit,
    output logic flag_q,
    output logic pend
);
    logic act;

    // Pick the active level and the selected edge according to polarity.
    always_comb begin
        act      = pol ? lvl : ~lvl;
        edge_hit = is_edge & (pol ? rise : fall);
        pend     = is_edge ? flag_q : act;
    end

    // Edge flag storage: the hardware set has the highest precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (!is_edge) begin
            flag_q <= 1'b0;
        end else if (edge_hit) begin
            flag_q <= 1'b1;
        end else if (wr_en) begin
            flag_q <= wr_val;
        end else if (ack_hit) begin
            flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/extint_regs.sv
// Module: configuration registers and read multiplexer.
// Holds the type, polarity, enable and two priority bits for each source.
// Flag writes are passed out as a strobe, because the flags live in the source slices.
// Assumes NSRC <= DW; unused bits and unused addresses read as zero.
module extint_regs
    import extint_pkg::*;
#(
    parameter int NSRC = 4,
    parameter int DW   = 8,
    parameter int AW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NSRC-1:0] pend,
    output logic [NSRC-1:0] type_q,
    output logic [NSRC-1:0] pol_q,
    output logic [NSRC-1:0] en_q,
    output logic [NSRC-1:0] plo_q,
    output logic [NSRC-1:0] phi_q,
    output logic            flag_we,
    output logic [NSRC-1:0] flag_wval
);
    logic [NSRC-1:0] wbits;

    // Slice the write data down to one bit per source.
    always_comb begin
        wbits     = bus_wdata[NSRC-1:0];
        flag_we   = bus_we && (bus_addr == AW'(RS_FLAG));
        flag_wval = wbits;
    end

    // Store the configuration fields on register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            type_q <= '0;
            pol_q  <= '0;
            en_q   <= '0;
            plo_q  <= '0;
            phi_q  <= '0;
        end else if (bus_we) begin
            if (bus_addr == AW'(RS_TYPE)) type_q <= wbits;
            if (bus_addr == AW'(RS_POL))  pol_q  <= wbits;
            if (bus_addr == AW'(RS_EN))   en_q   <= wbits;
            if (bus_addr == AW'(RS_PLO))  plo_q  <= wbits;
            if (bus_addr == AW'(RS_PHI))  phi_q  <= wbits;
        end
    end

    // Combinational readback with reserved bits forced to zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(RS_TYPE))      bus_rdata[NSRC-1:0] = type_q;
        else if (bus_addr == AW'(RS_POL))  bus_rdata[NSRC-1:0] = pol_q;
        else if (bus_addr == AW'(RS_EN))   bus_rdata[NSRC-1:0] = en_q;
        else if (bus_addr == AW'(RS_FLAG)) bus_rdata[NSRC-1:0] = pend;
        else if (bus_addr == AW'(RS_PLO))  bus_rdata[NSRC-1:0] = plo_q;
        else if (bus_addr == AW'(RS_PHI))  bus_rdata[NSRC-1:0] = phi_q;
    end
endmodule

// File: rtl/extint_arb.sv
// Module: fixed-order priority selector.
// Picks the eligible source with the highest level, and the lowest index on a tie.
// Purely combinational; assumes NSRC is small, so a linear scan is shallow.
module extint_arb
    import extint_pkg::*;
#(
    parameter int NSRC = 4,
    parameter int IDXW = 2
) (
    input  logic [NSRC-1:0]             elig,
    input  logic [NSRC-1:0][LVL_W-1:0]  lvl,
    output logic                        found,
    output logic [IDXW-1:0]             win_idx,
    output prio_t                       win_lvl
);
    // Scan upward and replace the candidate only on a strictly higher level.
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (elig[i] && (!found || (lvl[i] > win_lvl))) begin
                found   = 1'b1;
                win_idx = IDXW'(i);
                win_lvl = lvl[i];
            end
        end
    end
endmodule

// File: rtl/extint_unit.sv
// Module: top of the external interrupt detect and priority unit.
// Synchronizes the pins, keeps one pending slice per source, holds the
// configuration registers and presents the winning request.
// Assumes a synchronous active-low reset and a one-cycle ack_valid at service start.
module extint_unit
    import extint_pkg::*;
#(
    parameter int NSRC = 4,
    parameter int DW   = 8,
    parameter int AW   = 3,
    parameter int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   pin_in,
    input  logic [NSRC-1:0]   src_mask,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              ack_valid,
    input  logic [IDXW-1:0]   ack_idx,
    output logic              irq_valid,
    output logic [IDXW-1:0]   irq_idx,
    output logic [LVL_W-1:0]  irq_level
);
    logic [NSRC-1:0] s_lvl, s_rise, s_fall;
    logic [NSRC-1:0] type_q, pol_q, en_q, plo_q, phi_q;
    logic [NSRC-1:0] flag_q, edge_hit, pend, elig, ack_hit;
    logic [NSRC-1:0][LVL_W-1:0] prio_lvl;
    logic            flag_we;
    logic [NSRC-1:0] flag_wval;
    prio_t           win_lvl;

    extint_sync #(.N(NSRC)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pin_in),
        .lvl       (s_lvl),
        .rise      (s_rise),
        .fall      (s_fall)
    );

    extint_regs #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pend      (pend),
        .type_q    (type_q),
        .pol_q     (pol_q),
        .en_q      (en_q),
        .plo_q     (plo_q),
        .phi_q     (phi_q),
        .flag_we   (flag_we),
        .flag_wval (flag_wval)
    );

    // One pending slice per source, plus its eligibility and level.
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign ack_hit[g]  = ack_valid && (ack_idx == IDXW'(g));
        assign prio_lvl[g] = {phi_q[g], plo_q[g]};
        assign elig[g]     = pend[g] & en_q[g] & ~src_mask[g];

        extint_src u_src (
            .clk      (clk),
            .rst_n    (rst_n),
            .is_edge  (type_q[g]),
            .pol      (pol_q[g]),
            .lvl      (s_lvl[g]),
            .rise     (s_rise[g]),
            .fall     (s_fall[g]),
            .wr_en    (flag_we),
            .wr_val   (flag_wval[g]),
            .ack_hit  (ack_hit[g]),
            .edge_hit (edge_hit[g]),
            .flag_q   (flag_q[g]),
            .pend     (pend[g])
        );
    end

    extint_arb #(.NSRC(NSRC), .IDXW(IDXW)) u_arb (
        .elig    (elig),
        .lvl     (prio_lvl),
        .found   (irq_valid),
        .win_idx (irq_idx),
        .win_lvl (win_lvl)
    );

    // Drive the level port from the arbiter result.
    always_comb irq_level = win_lvl;
endmodule

// File: rtl/extint_unit_chk.sv
// Checker: cycle-level properties of the external interrupt unit, bound to the top.
module extint_unit_chk #(
    parameter int NSRC = 4,
    parameter int IDXW = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] src_mask,
    input logic [NSRC-1:0] type_q,
    input logic [NSRC-1:0] en_q,
    input logic [NSRC-1:0] plo_q,
    input logic [NSRC-1:0] phi_q,
    input logic [NSRC-1:0] pend,
    input logic [NSRC-1:0] flag_q,
    input logic [NSRC-1:0] edge_hit,
    input logic            flag_we,
    input logic            ack_valid,
    input logic [IDXW-1:0] ack_idx,
    input logic            irq_valid,
    input logic [IDXW-1:0] irq_idx,
    input logic [1:0]      irq_level
);
    logic [NSRC-1:0] ok_src;
    logic            ack_plain;

    // Sources eligible by enable, mask and pending; used to judge the winner.
    always_comb begin
        ok_src    = pend & en_q & ~src_mask;
        ack_plain = ack_valid && type_q[ack_idx] && !edge_hit[ack_idx] && !flag_we;
    end

    assert_winner_eligible_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (pend[irq_idx] && en_q[irq_idx] && !src_mask[irq_idx]));

    assert_any_eligible_raises_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|ok_src) |-> irq_valid);

    assert_level_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_level == {phi_q[irq_idx], plo_q[irq_idx]}));

    assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_plain |=> !flag_q[$past(ack_idx)]);

    for (genvar j = 0; j < NSRC; j++) begin : g_chk
        assert_no_outrank_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (ok_src[j] && irq_valid) |-> ({phi_q[j], plo_q[j]} <= irq_level));

        assert_edge_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
            edge_hit[j] |=> flag_q[j]);
    end
endmodule

bind extint_unit extint_unit_chk #(.NSRC(NSRC), .IDXW(IDXW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_mask  (src_mask),
    .type_q    (type_q),
    .en_q      (en_q),
    .plo_q     (plo_q),
    .phi_q     (phi_q),
    .pend      (pend),
    .flag_q    (flag_q),
    .edge_hit  (edge_hit),
    .flag_we   (flag_we),
    .ack_valid (ack_valid),
    .ack_idx   (ack_idx),
    .irq_valid (irq_valid),
    .irq_idx   (irq_idx),
    .irq_level (irq_level)
);

// File: tb/extint_unit_test.sv
`timescale 1ns/1ps
module extint_unit_test;
    localparam int NSRC = 4;
    localparam int DW   = 8;
    localparam int AW   = 3;
    localparam int IDXW = 2;
    localparam int CLKP = 20;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] pin_in = '1;
    logic [NSRC-1:0] src_mask = '0;
    logic            bus_we = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [DW-1:0]   bus_wdata = '0;
    logic [DW-1:0]   bus_rdata;
    logic            ack_valid = 1'b0;
    logic [IDXW-1:0] ack_idx = '0;
    logic            irq_valid;
    logic [IDXW-1:0] irq_idx;
    logic [1:0]      irq_level;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLKP/2) clk = ~clk;

    extint_unit #(.NSRC(NSRC), .DW(DW), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .src_mask(src_mask),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ack_valid(ack_valid), .ack_idx(ack_idx),
        .irq_valid(irq_valid), .irq_idx(irq_idx), .irq_level(irq_level)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = AW'(addr); bus_wdata = DW'(data);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int addr, output int data);
        @(negedge clk);
        bus_addr = AW'(addr);
        #2 data = int'(bus_rdata);
    endtask

    task automatic ack(input int idx);
        @(negedge clk);
        ack_valid = 1'b1; ack_idx = IDXW'(idx);
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    // Bench model for the winner: highest level, then lowest index.
    function automatic int model_win(input logic [NSRC-1:0] el, input logic [NSRC-1:0] lo,
                                     input logic [NSRC-1:0] hi, output int lvl);
        int best = -1;
        lvl = 0;
        for (int i = 0; i < NSRC; i++) begin
            int l = {hi[i], lo[i]};
            if (el[i] && (best < 0 || l > lvl)) begin
                best = i; lvl = l;
            end
        end
        return best;
    endfunction

    initial begin
        #(CLKP * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int v;
        int seed;
        cycles(3);
        rst_n = 1'b1;
        cycles(5);

        // R8: reset values; pins idle high so level-low sources are inactive.
        for (int a = 0; a < 8; a++) begin
            rd(a, v);
            check($sformatf("R8 reset addr %0d", a), v, 0);
        end
        check("R8 irq_valid after reset", int'(irq_valid), 0);

        // R9: reserved bits and addresses read zero.
        wr(4, 8'hFF);
        rd(4, v); check("R9 upper bits of priority-low register", v, 8'h0F);
        wr(6, 8'hFF);
        rd(6, v); check("R9 address 6 reads zero", v, 0);
        wr(4, 0);

        // R1: level low on source 0.
        wr(2, 4'b0001);
        pin_in[0] = 1'b0; cycles(4);
        check("R1 low level raises", int'(irq_valid), 1);
        check("R1 winner index", int'(irq_idx), 0);
        rd(3, v); check("R1 flag readback low level", v & 1, 1);
        pin_in[0] = 1'b1; cycles(4);
        check("R1 level released", int'(irq_valid), 0);
        wr(1, 4'b0001); cycles(1);
        check("R1 high level with polarity", int'(irq_valid), 1);

        // R3 / R4: acknowledge and flag writes are ignored in level mode.
        ack(0); cycles(1);
        check("R3 ack ignored in level mode", int'(irq_valid), 1);
        wr(3, 0); rd(3, v);
        check("R4 write ignored in level mode", v & 1, 1);
        wr(2, 0); wr(1, 0);

        // R2: falling edge on source 1.
        wr(0, 4'b0010);
        pin_in[1] = 1'b0; cycles(4);
        rd(3, v); check("R2 falling edge latches", (v >> 1) & 1, 1);
        pin_in[1] = 1'b1; cycles(4);
        rd(3, v); check("R2 flag holds after pin returns", (v >> 1) & 1, 1);
        ack(1); rd(3, v);
        check("R3 ack clears edge flag", (v >> 1) & 1, 0);
        wr(1, 4'b0010);
        pin_in[1] = 1'b0; cycles(4);
        rd(3, v); check("R2 opposite edge ignored", (v >> 1) & 1, 0);
        pin_in[1] = 1'b1; cycles(4);
        rd(3, v); check("R2 rising edge latches", (v >> 1) & 1, 1);

        // R4: CPU clears and sets the edge flag.
        wr(3, 0); rd(3, v); check("R4 write clears edge flag", (v >> 1) & 1, 0);
        wr(3, 4'b0010); rd(3, v); check("R4 write sets edge flag", (v >> 1) & 1, 1);

        // R5: falling-edge source 2, with a clearing write landing on the edge cycle.
        wr(0, 4'b0100); wr(1, 0);
        wr(3, 4'b0100);
        @(negedge clk); pin_in[2] = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk); bus_we = 1'b1; bus_addr = 3'd3; bus_wdata = 0;
        @(negedge clk); bus_we = 1'b0;
        rd(3, v); check("R5 edge beats clearing write", (v >> 2) & 1, 1);

        // R6: pending edge source masked or disabled.
        wr(2, 4'b0100); cycles(1);
        check("R6 enabled pending raises", int'(irq_valid), 1);
        src_mask = 4'b0100; cycles(1);
        check("R6 mask forces off", int'(irq_valid), 0);
        src_mask = 0; wr(2, 0); cycles(1);
        check("R6 disabled source quiet", int'(irq_valid), 0);
        pin_in[2] = 1'b1;

        // R7: directed tie and outrank, in level mode.
        wr(0, 0); wr(1, 0); pin_in = 4'b0000;
        wr(2, 4'b0110); wr(5, 4'b0110); cycles(4);
        check("R7 tie goes to lowest index", int'(irq_idx), 1);
        check("R7 tie level", int'(irq_level), 2);
        wr(2, 4'b1110); wr(4, 4'b1000); wr(5, 4'b1110); cycles(1);
        check("R7 higher level wins", int'(irq_idx), 3);
        check("R7 top level", int'(irq_level), 3);

        // R7 / R1 / R6: random level-mode configurations.
        seed = 32'h5EED;
        void'($urandom(seed));
        for (int it = 0; it < 80; it++) begin
            logic [NSRC-1:0] p, en, lo, hi, mk, pins, act;
            int wl, wi;
            p = NSRC'($urandom); en = NSRC'($urandom); lo = NSRC'($urandom);
            hi = NSRC'($urandom); mk = NSRC'($urandom); pins = NSRC'($urandom);
            wr(1, p); wr(2, en); wr(4, lo); wr(5, hi);
            src_mask = mk; pin_in = pins;
            cycles(4);
            act = p ? 0 : 0;
            for (int i = 0; i < NSRC; i++) act[i] = p[i] ? pins[i] : ~pins[i];
            wi = model_win(act & en & ~mk, lo, hi, wl);
            check("R7 random valid", int'(irq_valid), (wi >= 0) ? 1 : 0);
            if (wi >= 0) begin
                check("R7 random index", int'(irq_idx), wi);
                check("R7 random level", int'(irq_level), wl);
            end
            rd(3, v); check("R1 random flag readback", v, int'(act));
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule